// File: doc/BRIEF.md
# SMII Receive Segment Encoder

This block is the PHY-side serializer of a serial media-independent receive path. All activity runs on one shared 125 MHz clock. The MAC sends a SYNC pulse once every ten clocks. On each pulse the encoder samples a receive byte with its valid, carrier and error flags, builds a ten-bit segment from them, and shifts the segment out on a single RXD line, one bit per clock.

When no receive data is valid, the byte slot carries a bit-mapped status word instead. It reports speed, duplex, link, jabber, upper-nibble validity and false carrier. It also reports whether the previous frame ended with a receive error. At 10 Mb/s the line still runs at the full segment rate, so each captured segment is sent ten times in a row.

Top module: `smii_rx_encoder`

## Requirements
- R1: The sampling edge is a clock edge at which `syncIn` is high. After that edge, RXD carries segment bit 0 for one clock, then bit 1, and so on through bit 9, one bit per clock. Bit 0 is carrier sense, bit 1 is receive data valid, and bits 2..9 are byte bits 0..7, least significant first.
- R2: When `rxValid` is 1 at the sampling edge, segment bits 2..9 equal `rxByte` as sampled at that edge.
- R3: When `rxValid` is 0, the byte slot holds the status word. Status bit 1 is `speed100` (1 = 100 Mb/s), bit 2 is `fullDuplex` (1 = full) and bit 3 is `linkUp` (1 = up).
- R4: In the status word, bit 4 is `jabber`, bit 5 is `nibbleOk`, bit 6 is `falseCarrier`, and bit 7 is always 1.
- R5: Status bit 0 is 1 when the most recent frame had `rxErr` high at any of its captured valid segments. A frame is a run of captures with `rxValid` high. The bit keeps its value until the next frame ends, and it is 0 after reset.
- R6: With `speed100` low, a new segment is captured only on every tenth SYNC. The nine SYNC pulses in between resend the held segment bit for bit, and they ignore the current inputs.
- R7: A SYNC pulse that arrives in the middle of a segment abandons the rest of that segment. The next clock starts a new segment at bit 0.
- R8: After reset, RXD stays low until the first SYNC. The first SYNC always captures a fresh segment.
- R9: If no SYNC arrives once bit 9 has been sent, RXD stays low until the next SYNC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz shared clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncIn | input | 1 | Segment start pulse from the MAC |
| rxByte | input | 8 | Received byte |
| rxValid | input | 1 | Receive data valid |
| rxCarrier | input | 1 | Carrier sense |
| rxErr | input | 1 | Receive error for the current byte |
| speed100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| fullDuplex | input | 1 | 1 = full duplex |
| linkUp | input | 1 | 1 = link up |
| jabber | input | 1 | Jabber detected |
| nibbleOk | input | 1 | Upper nibble valid |
| falseCarrier | input | 1 | False carrier detected |
| rxdOut | output | 1 | Serial receive data line |

## Verification
Two functions can fall on the same clock: a realigning SYNC that cuts a segment short, and the 10 Mb/s repeat counter deciding between resend and recapture. The bench runs 10 Mb/s mode with random SYNC spacing, both shorter and longer than a segment. Each early pulse must restart a full copy of the held segment, and it must still advance the repeat count, so that a fresh capture appears only on the tenth pulse. Every RXD bit is compared with a bench model that is built from the requirements.

// File: rtl/smii_rx_pkg.sv
package smii_rx_pkg;
  localparam int DATA_W = 8;
  localparam int SEG_W  = DATA_W + 2;

  typedef struct packed {
    logic load;    // capture a fresh segment
    logic resend;  // restart the held segment
    logic shift;   // advance to the next bit
    logic active;  // a segment is on the line
  } segStrobe_t;
endpackage

// File: rtl/smii_rx_ctrl.sv
module smii_rx_ctrl
  import smii_rx_pkg::*;
#(
  parameter int REPEAT = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncIn,
  input  logic       speed100,
  output segStrobe_t strobe
);
  localparam int CW = $clog2(SEG_W);
  localparam int RW = (REPEAT > 1) ? $clog2(REPEAT) : 1;

  logic [CW-1:0] bitCnt;
  logic [RW-1:0] repCnt;
  logic          primed;
  logic          active;
  logic          lastBit;
  logic          doLoad;

  assign lastBit = (bitCnt == CW'(SEG_W - 1));
  assign doLoad  = syncIn && (speed100 || !primed || (repCnt == RW'(REPEAT - 1)));

  always_comb begin
    strobe.load   = doLoad;
    strobe.resend = syncIn && !doLoad;
    strobe.shift  = !syncIn && active && !lastBit;
    strobe.active = active;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      repCnt <= '0;
      primed <= 1'b0;
      active <= 1'b0;
    end else if (syncIn) begin
      active <= 1'b1;
      bitCnt <= '0;
      primed <= 1'b1;
      repCnt <= doLoad ? '0 : repCnt + RW'(1);
    end else if (active) begin
      if (lastBit) active <= 1'b0;
      else         bitCnt <= bitCnt + CW'(1);
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt < CW'(SEG_W)); // R1
  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    syncIn |=> (active && bitCnt == '0)); // R7
  AST_SEG_END_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (active && !syncIn && lastBit) |=> !active); // R9
  AST_QUIET_UNTIL_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    !primed |-> !active); // R8
  AST_SLOW_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (syncIn && primed && !speed100 && repCnt != RW'(REPEAT - 1)) |-> !strobe.load); // R6
endmodule

// File: rtl/smii_rx_status.sv
module smii_rx_status
  import smii_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              rxValid,
  input  logic              rxErr,
  input  logic              speed100,
  input  logic              fullDuplex,
  input  logic              linkUp,
  input  logic              jabber,
  input  logic              nibbleOk,
  input  logic              falseCarrier,
  output logic [DATA_W-1:0] statusWord
);
  logic errAcc;
  logic prevErr;
  logic lastValid;
  logic frameEnd;
  logic errFlag;

  assign frameEnd = lastValid && !rxValid;
  assign errFlag  = frameEnd ? errAcc : prevErr;

  always_comb begin
    statusWord    = '0;
    statusWord[0] = errFlag;
    statusWord[1] = speed100;
    statusWord[2] = fullDuplex;
    statusWord[3] = linkUp;
    statusWord[4] = jabber;
    statusWord[5] = nibbleOk;
    statusWord[6] = falseCarrier;
    statusWord[7] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errAcc    <= 1'b0;
      prevErr   <= 1'b0;
      lastValid <= 1'b0;
    end else if (load) begin
      lastValid <= rxValid;
      if (rxValid) begin
        errAcc <= (lastValid ? errAcc : 1'b0) | rxErr;
      end else if (frameEnd) begin
        prevErr <= errAcc;
        errAcc  <= 1'b0;
      end
    end
  end

  AST_ERR_FLAG_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (load && !rxValid && !lastValid) |=> $stable(prevErr)); // R5
endmodule

// File: rtl/smii_rx_datapath.sv
module smii_rx_datapath
  import smii_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  segStrobe_t        strobe,
  input  logic              rxCarrier,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxByte,
  input  logic [DATA_W-1:0] statusWord,
  output logic              rxdOut
);
  logic [SEG_W-1:0] shiftReg;
  logic [SEG_W-1:0] heldSeg;
  logic [SEG_W-1:0] newSeg;

  assign newSeg = {(rxValid ? rxByte : statusWord), rxValid, rxCarrier};
  assign rxdOut = strobe.active & shiftReg[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      heldSeg  <= '0;
    end else if (strobe.load) begin
      shiftReg <= newSeg;
      heldSeg  <= newSeg;
    end else if (strobe.resend) begin
      shiftReg <= heldSeg;
    end else if (strobe.shift) begin
      shiftReg <= shiftReg >> 1;
    end
  end

  AST_DATA_PLACED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && rxValid) |=> shiftReg[SEG_W-1:2] == $past(rxByte)); // R2
  AST_STATUS_TOP_SET: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !rxValid) |=> shiftReg[SEG_W-1]); // R4
  AST_RESEND_COPY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.resend |=> shiftReg == $past(heldSeg)); // R6
endmodule

// File: rtl/smii_rx_encoder.sv
module smii_rx_encoder
  import smii_rx_pkg::*;
#(
  parameter int REPEAT = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncIn,
  input  logic [7:0] rxByte,
  input  logic       rxValid,
  input  logic       rxCarrier,
  input  logic       rxErr,
  input  logic       speed100,
  input  logic       fullDuplex,
  input  logic       linkUp,
  input  logic       jabber,
  input  logic       nibbleOk,
  input  logic       falseCarrier,
  output logic       rxdOut
);
  segStrobe_t        strobe;
  logic [DATA_W-1:0] statusWord;

  smii_rx_ctrl #(.REPEAT(REPEAT)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .syncIn   (syncIn),
    .speed100 (speed100),
    .strobe   (strobe)
  );

  smii_rx_status uStatus (
    .clk          (clk),
    .rstN         (rstN),
    .load         (strobe.load),
    .rxValid      (rxValid),
    .rxErr        (rxErr),
    .speed100     (speed100),
    .fullDuplex   (fullDuplex),
    .linkUp       (linkUp),
    .jabber       (jabber),
    .nibbleOk     (nibbleOk),
    .falseCarrier (falseCarrier),
    .statusWord   (statusWord)
  );

  smii_rx_datapath uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rxCarrier  (rxCarrier),
    .rxValid    (rxValid),
    .rxByte     (rxByte),
    .statusWord (statusWord),
    .rxdOut     (rxdOut)
  );
endmodule

// File: tb/sim_smii_rx_encoder.sv
module sim_smii_rx_encoder;
  localparam int CLK_PERIOD = 8;
  localparam int REP = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic syncIn = 1'b0;
  logic [7:0] rxByte = '0;
  logic rxValid = 1'b0, rxCarrier = 1'b0, rxErr = 1'b0;
  logic speed100 = 1'b1, fullDuplex = 1'b0, linkUp = 1'b0;
  logic jabber = 1'b0, nibbleOk = 1'b0, falseCarrier = 1'b0;
  logic rxdOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench model state
  bit       mActive = 0, mPrimed = 0, mRepeated = 0, mRealigned = 0;
  int       mIdx = 0, mRep = 0;
  bit [9:0] mSeg = '0, mHeld = '0;
  bit       mErrAcc = 0, mPrev = 0, mLastV = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smii_rx_encoder u0 (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .rxByte(rxByte),
    .rxValid(rxValid), .rxCarrier(rxCarrier), .rxErr(rxErr),
    .speed100(speed100), .fullDuplex(fullDuplex), .linkUp(linkUp),
    .jabber(jabber), .nibbleOk(nibbleOk), .falseCarrier(falseCarrier),
    .rxdOut(rxdOut)
  );

  function automatic bit [9:0] buildSeg(bit errBit);
    bit [7:0] slot;
    if (rxValid) slot = rxByte;
    else slot = {1'b1, falseCarrier, nibbleOk, jabber, linkUp, fullDuplex, speed100, errBit};
    return {slot, rxValid, rxCarrier};
  endfunction

  // advances the model for the coming clock edge
  task automatic modelStep();
    bit errBit;
    if (!rstN) begin
      mActive = 0; mPrimed = 0; mRep = 0; mErrAcc = 0; mPrev = 0; mLastV = 0;
      return;
    end
    if (syncIn) begin
      mRealigned = mActive && (mIdx != 9);
      if (speed100 || !mPrimed || mRep == REP-1) begin
        errBit = (mLastV && !rxValid) ? mErrAcc : mPrev;
        mSeg = buildSeg(errBit);
        mHeld = mSeg;
        if (rxValid) mErrAcc = (mLastV ? mErrAcc : 1'b0) | rxErr;
        else if (mLastV) begin mPrev = mErrAcc; mErrAcc = 0; end
        mLastV = rxValid;
        mRep = 0;
        mRepeated = 0;
      end else begin
        mSeg = mHeld;
        mRep++;
        mRepeated = 1;
      end
      mPrimed = 1; mActive = 1; mIdx = 0;
    end else if (mActive) begin
      if (mIdx == 9) mActive = 0;
      else mIdx++;
    end
  endtask

  function automatic string tagFor();
    if (!mActive) return mPrimed ? "R9" : "R8";
    if (mRepeated) return "R6";
    if (mRealigned) return "R7";
    if (mIdx < 2) return "R1";
    if (mSeg[1]) return "R2";
    if (mIdx == 2) return "R5";
    if (mIdx <= 5) return "R3";
    return "R4";
  endfunction

  // one clock: inputs already set at a falling edge
  task automatic cycle();
    bit expBit;
    string tag;
    modelStep();
    expBit = mActive ? mSeg[mIdx] : 1'b0;
    tag = tagFor();
    @(posedge clk);
    @(negedge clk);
    total++;
    if (rxdOut !== expBit) begin
      bad++;
      $display("FAIL %s: rxd=%0b expected=%0b (bit %0d, t=%0t)", tag, rxdOut, expBit, mIdx, $time);
    end
  endtask

  task automatic randInputs(int validBias);
    rxByte = 8'($urandom);
    rxValid = ($urandom % 100) < validBias;
    rxCarrier = rxValid | ($urandom % 2 == 0);
    rxErr = ($urandom % 4) == 0;
    fullDuplex = 1'($urandom); linkUp = 1'($urandom); jabber = 1'($urandom);
    nibbleOk = 1'($urandom); falseCarrier = 1'($urandom);
  endtask

  task automatic runSegments(int n, int minGap, int maxGap, int validBias);
    for (int s = 0; s < n; s++) begin
      int gap;
      gap = minGap + int'($urandom % (maxGap - minGap + 1));
      randInputs(validBias);
      syncIn = 1'b1;
      cycle();
      syncIn = 1'b0;
      for (int k = 1; k < gap; k++) begin
        randInputs(validBias);
        cycle();
      end
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    // R8: reset and quiet line before any SYNC
    for (int i = 0; i < 3; i++) cycle();
    rstN = 1'b1;
    for (int i = 0; i < 6; i++) cycle();
    // R1 R2 R3 R4: 100 Mb/s, regular SYNC
    speed100 = 1'b1;
    runSegments(40, 10, 10, 60);
    // R5: directed erroneous frame then status
    rxValid = 1'b1; rxErr = 1'b1; rxByte = 8'hA5; syncIn = 1'b1; cycle(); syncIn = 1'b0;
    rxErr = 1'b0;
    for (int k = 1; k < 10; k++) cycle();
    rxValid = 1'b0; syncIn = 1'b1; cycle(); syncIn = 1'b0;
    for (int k = 1; k < 10; k++) cycle();
    syncIn = 1'b1; cycle(); syncIn = 1'b0;      // flag persists
    for (int k = 1; k < 10; k++) cycle();
    // R5: clean frame clears the flag
    rxValid = 1'b1; syncIn = 1'b1; cycle(); syncIn = 1'b0;
    for (int k = 1; k < 10; k++) cycle();
    rxValid = 1'b0; syncIn = 1'b1; cycle(); syncIn = 1'b0;
    for (int k = 1; k < 10; k++) cycle();
    // R9: gaps longer than a segment
    runSegments(15, 11, 16, 50);
    // R7: early SYNC at 100 Mb/s
    runSegments(30, 2, 12, 50);
    // R6: 10 Mb/s with regular SYNC
    speed100 = 1'b0;
    runSegments(45, 10, 10, 50);
    // R6 with R7: early SYNC while repeating
    runSegments(60, 3, 13, 50);
    speed100 = 1'b1;
    runSegments(20, 1, 12, 50);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule